// File: doc/BRIEF.md
# Timekeeping Register Slave on a Two-Wire Serial Bus

This block is the serial-bus front end of a clock/calendar. It watches the clock and data lines of a two-wire I2C bus and recognises START and STOP. It answers one fixed 7-bit device address and serves a ten-location register file. The register file holds seven time bytes, a control byte, a charger configuration byte and a status byte with a sticky oscillator-stop flag. Both bus lines are open drain: the block never drives high, it only asserts `sda_oe_o` to pull the data line low. The two lines are oversampled by the system clock, with a synchroniser and a majority-style stability filter, so standard and fast mode both work when the system clock is much faster than the bus. The block never stretches the bus clock.

Time reads are coherent. A seven-byte user buffer captures the live time from the calendar on three events: a START, a STOP, and the pointer stepping to 00h. Reads of the time locations come from this buffer. Writes to locations 00h–07h are passed to the calendar and divider logic as a one-cycle strobe. The block also keeps its own copy of the control byte. While the power-fail input is high the bus is shut out, and the calendar keeps counting.

Top module: `clkreg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal 1101000. Its last bit selects the direction: 0 for write, 1 for read. For any other address the slave never pulls the data line low before the next START.
- R2: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. Either one abandons any byte in progress, and a repeated START begins a new address phase. `sda_oe_o` changes only while the filtered clock line is low.
- R3: In a write transfer, the first data byte loads the pointer from its low four bits. Each later byte is written to the pointed location, and the pointer then steps. Every byte of an addressed transfer is acknowledged.
- R4: A byte written to locations 00h–07h gives a one-cycle `wr_stb_o` with `wr_idx_o` equal to the location and `wr_dat_o` equal to the byte. This happens when the acknowledge is driven. A write to 07h also updates `ctrl_o`, which resets to 80h.
- R5: A read transfer starts at the current pointer, including a pointer left over from an earlier transfer. It sends bytes MSB first until the master does not acknowledge, and then the slave releases the line.
- R6: The pointer steps 07h→00h and 09h→00h, and otherwise steps by one. 08h and 09h are reached only by loading the pointer. Locations 0Ah–0Fh read 00h, ignore writes, and step to 00h.
- R7: A START, a STOP and every pointer step to 00h copy `live_time_i` into the user buffer and pulse `snap_o` one cycle later. Location k (0–6) reads byte k of the buffer, which is bits 8k+7..8k. The copy does not follow later changes of the live time.
- R8: The charger byte at 08h resets to 00h and appears on `trickle_o`. `chg_en_o` is 1 only when all three of these hold: bits 7:4 are 1010, bits 3:2 are 01 or 10, and bits 1:0 are not 00.
- R9: Location 09h reads {flag, 0000000}. The flag is 1 after reset and is set by each rising edge of `osc_stop_i`. A write with bit 7 equal to 0 clears it, and a write with bit 7 equal to 1 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: While `pwr_fail_i` is 1, the address byte is not acknowledged, and a data byte is neither acknowledged nor written. The transfer is then dropped until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| pwr_fail_i | input | 1 | Supply below threshold; blocks bus access |
| osc_stop_i | input | 1 | Oscillator stopped indication; rising edge sets the flag |
| live_time_i | input | 56 | Live time bytes from the calendar, byte k at bits 8k+7..8k |
| snap_o | output | 1 | Pulse when the user buffer was reloaded |
| wr_stb_o | output | 1 | One-cycle write strobe for locations 00h–07h |
| wr_idx_o | output | 3 | Location of the write |
| wr_dat_o | output | 8 | Byte written |
| ctrl_o | output | 8 | Control byte (location 07h) |
| trickle_o | output | 8 | Charger configuration byte (location 08h) |
| chg_en_o | output | 1 | Decoded charger enable |

## Verification
The bench targets these corner cases:
- A read that runs across 07h into 00h. It must return a freshly captured time byte; a design that snapshots only on START would return stale time.
- Reads that cross 09h or start at an unused pointer value. Each must land on 00h; a plain incrementing pointer would walk into empty locations.
- A byte cut short by a repeated START. It must leave no write behind.
- Writes of 1 to the status flag. They must not set it; a plain register would.
- Writes that pair a correct upper nibble with a forbidden diode or resistor code. These must keep the charger disabled.
- Power failure mid-transfer. It must stop the acknowledge as well as the write.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  localparam int          BYTE_W     = 8;
  localparam int          TIME_BYTES = 7;
  localparam int          PTR_W      = 4;
  localparam logic [3:0]  LOC_CTRL   = 4'd7;
  localparam logic [3:0]  LOC_CHG    = 4'd8;
  localparam logic [3:0]  LOC_FLAG   = 4'd9;
  localparam logic [7:0]  CTRL_RST   = 8'h80;

  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_AACK, L_WR, L_WACK, L_RD, L_RACK
  } link_st_t;

  // pointer step: the time/control window wraps at 07h, the extra window at 09h
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    if (p == LOC_CTRL || p >= LOC_FLAG) return '0;
    return p + 4'd1;
  endfunction
endpackage

// File: rtl/crs_bus_sense.sv
`timescale 1ns/1ps
module crs_bus_sense #(
  parameter int STAGES = 2,
  parameter int FILT   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_c,
  output logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [1:0] raw;
  logic [1:0] clean;
  logic       scl_q, sda_q;

  assign raw = {sda_raw, scl_raw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] sy;
    logic [FILT-1:0]   hist;
    logic              cln;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sy   <= '1;
        hist <= '1;
        cln  <= 1'b1;
      end else begin
        sy   <= {sy[STAGES-2:0], raw[g]};
        hist <= {hist[FILT-2:0], sy[STAGES-1]};
        if (&hist)       cln <= 1'b1;
        else if (~|hist) cln <= 1'b0;
      end
    end
    assign clean[g] = cln;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= clean[0];
      sda_q <= clean[1];
    end
  end

  assign scl_c    = clean[0];
  assign sda_c    = clean[1];
  assign scl_rise = clean[0] & ~scl_q;
  assign scl_fall = ~clean[0] & scl_q;
  assign start_c  = clean[0] & scl_q & sda_q & ~clean[1];
  assign stop_c   = clean[0] & scl_q & ~sda_q & clean[1];
endmodule

// File: rtl/crs_link.sv
`timescale 1ns/1ps
module crs_link
  import crs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             pwr_fail,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic             sda_oe,
  output logic             ptr_ld,
  output logic             data_wr,
  output logic             ptr_inc,
  output logic [BYTE_W-1:0] rx_byte
);
  link_st_t          st;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        bcnt;
  logic              rw, first, nack;
  logic              byte_end, cond, hit;

  assign cond     = start_c | stop_c;
  assign byte_end = scl_fall && (bcnt == 4'd8) && !cond;
  assign hit      = (sh[7:1] == DEV_ADDR) && !pwr_fail;
  assign rx_byte  = sh;

  always_comb begin
    ptr_ld  = 1'b0;
    data_wr = 1'b0;
    ptr_inc = 1'b0;
    if (st == L_WR && byte_end && !pwr_fail) begin
      ptr_ld  = first;
      data_wr = !first;
    end
    if (st == L_RD && byte_end) ptr_inc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= L_IDLE;
      sh     <= '0;
      bcnt   <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      nack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= L_ADDR;
      bcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= L_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        L_ADDR, L_WR: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            if (st == L_ADDR) begin
              if (hit) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= L_AACK;
              end else begin
                st <= L_IDLE;
              end
            end else if (pwr_fail) begin
              st <= L_IDLE;
            end else begin
              sda_oe <= 1'b1;
              st     <= L_WACK;
            end
          end
        end
        L_AACK: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (rw) begin
              sh     <= rd_byte;
              sda_oe <= !rd_byte[7];
              st     <= L_RD;
            end else begin
              sda_oe <= 1'b0;
              first  <= 1'b1;
              st     <= L_WR;
            end
          end
        end
        L_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bcnt   <= '0;
            first  <= 1'b0;
            st     <= L_WR;
          end
        end
        L_RD: begin
          if (scl_rise) begin
            bcnt <= bcnt + 4'd1;
          end else if (scl_fall) begin
            if (bcnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= L_RACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= !sh[6];
            end
          end
        end
        L_RACK: begin
          if (scl_rise) begin
            nack <= sda_s;
          end else if (scl_fall) begin
            if (nack || pwr_fail) begin
              st <= L_IDLE;
            end else begin
              sh     <= rd_byte;
              sda_oe <= !rd_byte[7];
              bcnt   <= '0;
              st     <= L_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crs_regs.sv
`timescale 1ns/1ps
module crs_regs
  import crs_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_c,
  input  logic                       stop_c,
  input  logic                       ptr_ld,
  input  logic                       data_wr,
  input  logic                       ptr_inc,
  input  logic [BYTE_W-1:0]          rx_byte,
  input  logic [TIME_BYTES*BYTE_W-1:0] live_time,
  input  logic                       osc_stop,
  output logic [BYTE_W-1:0]          rd_byte,
  output logic                       snap_o,
  output logic                       wr_stb,
  output logic [2:0]                 wr_idx,
  output logic [BYTE_W-1:0]          wr_dat,
  output logic [BYTE_W-1:0]          ctrl,
  output logic [BYTE_W-1:0]          trickle,
  output logic                       chg_en,
  output logic [PTR_W-1:0]           ptr_o,
  output logic                       osf_o,
  output logic                       osc_rise_o
);
  logic [PTR_W-1:0]  ptr, step;
  logic              inc_any, snap_req, osc_q, osf;
  logic [BYTE_W-1:0] tbuf [TIME_BYTES];

  assign step     = ptr_step(ptr);
  assign inc_any  = data_wr | ptr_inc;
  assign snap_req = start_c | stop_c | (inc_any && step == '0);
  assign osc_rise_o = osc_stop & ~osc_q;

  for (genvar k = 0; k < TIME_BYTES; k++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rst_n)        tbuf[k] <= '0;
      else if (snap_req) tbuf[k] <= live_time[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      snap_o  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_dat  <= '0;
      ctrl    <= CTRL_RST;
      trickle <= '0;
      osc_q   <= 1'b0;
      osf     <= 1'b1;
    end else begin
      snap_o <= snap_req;
      osc_q  <= osc_stop;
      wr_stb <= 1'b0;
      if (ptr_ld)       ptr <= rx_byte[PTR_W-1:0];
      else if (inc_any) ptr <= step;
      if (data_wr) begin
        if (ptr <= LOC_CTRL) begin
          wr_stb <= 1'b1;
          wr_idx <= ptr[2:0];
          wr_dat <= rx_byte;
        end
        if (ptr == LOC_CTRL) ctrl    <= rx_byte;
        if (ptr == LOC_CHG)  trickle <= rx_byte;
      end
      if (osc_rise_o)                                      osf <= 1'b1;
      else if (data_wr && ptr == LOC_FLAG && !rx_byte[7])  osf <= 1'b0;
    end
  end

  always_comb begin
    rd_byte = '0;
    if (ptr < LOC_CTRL) begin
      for (int k = 0; k < TIME_BYTES; k++)
        if (ptr == PTR_W'(k)) rd_byte = tbuf[k];
    end else if (ptr == LOC_CTRL) begin
      rd_byte = ctrl;
    end else if (ptr == LOC_CHG) begin
      rd_byte = trickle;
    end else if (ptr == LOC_FLAG) begin
      rd_byte = {osf, 7'b0};
    end
  end

  assign chg_en = (trickle[7:4] == 4'b1010) &&
                  (trickle[3:2] == 2'b01 || trickle[3:2] == 2'b10) &&
                  (trickle[1:0] != 2'b00);
  assign ptr_o  = ptr;
  assign osf_o  = osf;
endmodule

// File: rtl/clkreg_i2c_slave.sv
`timescale 1ns/1ps
module clkreg_i2c_slave
  import crs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  localparam int        LIVE_W      = TIME_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pwr_fail_i,
  input  logic              osc_stop_i,
  input  logic [LIVE_W-1:0] live_time_i,
  output logic              snap_o,
  output logic              wr_stb_o,
  output logic [2:0]        wr_idx_o,
  output logic [7:0]        wr_dat_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        trickle_o,
  output logic              chg_en_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic             ptr_ld_w, data_wr_w, ptr_inc_w, osf_w, osc_rise_w;
  logic [7:0]       rd_byte_w, rx_byte_w;
  logic [PTR_W-1:0] ptr_w;

  crs_bus_sense #(.STAGES(SYNC_STAGES), .FILT(FILT_LEN)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_c(scl_s), .sda_c(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_w), .stop_c(stop_w)
  );

  crs_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_c(start_w), .stop_c(stop_w), .pwr_fail(pwr_fail_i),
    .rd_byte(rd_byte_w), .sda_oe(sda_oe_o), .ptr_ld(ptr_ld_w),
    .data_wr(data_wr_w), .ptr_inc(ptr_inc_w), .rx_byte(rx_byte_w)
  );

  crs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .start_c(start_w), .stop_c(stop_w),
    .ptr_ld(ptr_ld_w), .data_wr(data_wr_w), .ptr_inc(ptr_inc_w),
    .rx_byte(rx_byte_w), .live_time(live_time_i), .osc_stop(osc_stop_i),
    .rd_byte(rd_byte_w), .snap_o(snap_o), .wr_stb(wr_stb_o),
    .wr_idx(wr_idx_o), .wr_dat(wr_dat_o), .ctrl(ctrl_o),
    .trickle(trickle_o), .chg_en(chg_en_o), .ptr_o(ptr_w),
    .osf_o(osf_w), .osc_rise_o(osc_rise_w)
  );
endmodule

// File: rtl/crs_chk.sv
`timescale 1ns/1ps
module crs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       pwr_fail,
  input logic       wr_stb,
  input logic [2:0] wr_idx,
  input logic [7:0] wr_dat,
  input logic [7:0] ctrl,
  input logic       osf,
  input logic       osc_rise,
  input logic [3:0] ptr,
  input logic       ptr_inc,
  input logic       stop_c,
  input logic       snap
);
  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_ctrl_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == 3'd7) |-> (ctrl == wr_dat));

  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr_inc) && ($past(ptr) == 4'd7 || $past(ptr) == 4'd9)) |-> (ptr == 4'd0));

  p_snap_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> snap);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osf) |-> $past(osc_rise));

  p_pf_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !$past(pwr_fail));
endmodule

bind clkreg_i2c_slave crs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .pwr_fail(pwr_fail_i), .wr_stb(wr_stb_o), .wr_idx(wr_idx_o),
  .wr_dat(wr_dat_o), .ctrl(ctrl_o), .osf(osf_w), .osc_rise(osc_rise_w),
  .ptr(ptr_w), .ptr_inc(ptr_inc_w), .stop_c(stop_w), .snap(snap_o)
);

// File: tb/clkreg_i2c_slave_tb.sv
`timescale 1ns/1ps
module clkreg_i2c_slave_tb;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h68;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0, osc_stop = 1'b0;
  logic [55:0] live_time = '0;
  logic sda_oe, snap, wr_stb, chg_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_dat, ctrl, trickle;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  clkreg_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pwr_fail_i(pwr_fail), .osc_stop_i(osc_stop), .live_time_i(live_time),
    .snap_o(snap), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_dat_o(wr_dat),
    .ctrl_o(ctrl), .trickle_o(trickle), .chg_en_o(chg_en)
  );

  int n_chk = 0, n_bad = 0;
  int wn = 0, en = 0, wchk = 0, sn = 0;
  logic [2:0] wl_idx [256];
  logic [7:0] wl_dat [256];
  logic [2:0] ex_idx [256];
  logic [7:0] ex_dat [256];

  // model state
  logic [3:0]  mptr = '0;
  logic [7:0]  mctrl = 8'h80, mtrk = 8'h00;
  logic        mosf = 1'b1;
  logic [55:0] msnap = '0;
  logic [7:0]  wbuf [16];

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin wl_idx[wn] = wr_idx; wl_dat[wn] = wr_dat; wn++; end
    if (rst_n && snap) sn++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] fstep(input logic [3:0] p);
    return (p == 4'd7 || p >= 4'd9) ? 4'd0 : p + 4'd1;
  endfunction

  function automatic logic [7:0] frd(input logic [3:0] p);
    if (p < 4'd7) return msnap[p*8 +: 8];
    if (p == 4'd7) return mctrl;
    if (p == 4'd8) return mtrk;
    if (p == 4'd9) return {mosf, 7'b0};
    return 8'h00;
  endfunction

  function automatic logic fchg(input logic [7:0] v);
    return v[7:4] == 4'hA && (v[3:2] == 2'b01 || v[3:2] == 2'b10) && v[1:0] != 2'b00;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
    msnap = live_time;
  endtask

  task automatic bstop();
    sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(Q);
    msnap = live_time;
  endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; wt(Q); scl_m = 1; wt(Q); seen = sda_line; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); b[i] = s; end
    bit_io(~mack, s);
  endtask

  task automatic mwrite(input logic [7:0] d);
    if (mptr <= 4'd7) begin ex_idx[en] = mptr[2:0]; ex_dat[en] = d; en++; end
    if (mptr == 4'd7) mctrl = d;
    if (mptr == 4'd8) mtrk = d;
    if (mptr == 4'd9 && !d[7]) mosf = 1'b0;
    mptr = fstep(mptr);
    if (mptr == 4'd0) msnap = live_time;
  endtask

  task automatic do_write(input logic [3:0] p, input int n);
    logic ak;
    bstart();
    send_byte({DEV, 1'b0}, ak);
    chk("R1 write address ack", ak, 1);
    send_byte({4'h0, p}, ak);
    chk("R3 pointer byte ack", ak, 1);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ak);
      chk("R3 data byte ack", ak, 1);
      mwrite(wbuf[k]);
    end
    bstop();
  endtask

  task automatic do_read(input int n, input logic swap, input logic [55:0] alt, input string tag);
    logic ak;
    logic [7:0] b;
    bstart();
    send_byte({DEV, 1'b1}, ak);
    chk("R1 read address ack", ak, 1);
    if (swap) live_time = alt;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(tag, b, frd(mptr));
      mptr = fstep(mptr);
      if (mptr == 4'd0) msnap = live_time;
    end
    bstop();
  endtask

  task automatic chk_wlog(input string tag);
    wt(4);
    chk(tag, wn, en);
    for (int i = wchk; i < en && i < wn; i++) begin
      chk({tag, " idx"}, wl_idx[i], ex_idx[i]);
      chk({tag, " data"}, wl_dat[i], ex_dat[i]);
    end
    wchk = en;
  endtask

  task automatic osc_pulse();
    osc_stop = 1; wt(3); osc_stop = 0; wt(3);
    mosf = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ak, s;
    logic [7:0] b;
    int seed, sn0, wn0;
    seed = $urandom(32'd1234);
    live_time = {$urandom, $urandom};
    wt(5); rst_n = 1; wt(5);

    // reset state
    chk("R2 reset sda_oe", sda_oe, 0);
    chk("R4 reset ctrl", ctrl, 8'h80);
    chk("R8 reset trickle", trickle, 8'h00);
    chk("R8 reset chg_en", chg_en, 0);
    do_write(4'd9, 0);
    do_read(1, 0, '0, "R9 flag after reset");

    // wrong address
    bstart();
    send_byte(8'hA0, ak);
    chk("R1 foreign address not acked", ak, 0);
    send_byte(8'h00, ak);
    chk("R1 no drive after foreign address", ak, 0);
    bstop();

    // control write and sequential write
    wbuf[0] = 8'h5A;
    do_write(4'd7, 1);
    chk("R4 ctrl_o after write", ctrl, 8'h5A);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(4'd2, 3);
    chk_wlog("R4 write strobes");

    // read across 07h wrap with live time changed mid-transfer
    live_time = {$urandom, $urandom};
    do_write(4'd0, 0);
    sn0 = sn;
    do_read(9, 1, {$urandom, $urandom}, "R7 snapshot read and wrap");
    wt(4);
    chk("R7 snapshot pulses start+wrap+stop", sn - sn0, 3);
    // read continues from remaining pointer
    do_read(2, 0, '0, "R5 read from held pointer");

    // charger decode
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = (i == 0) ? 8'hA5 : (i == 1) ? 8'hA6 : (i == 2) ? 8'hA4 :
          (i == 3) ? 8'hAD : (i == 4) ? 8'h55 : 8'hAB;
      wbuf[0] = v;
      do_write(4'd8, 1);
      chk("R8 trickle value", trickle, v);
      chk("R8 charger enable decode", chg_en, fchg(v));
    end
    // 08 -> 09 -> 00
    do_write(4'd8, 0);
    do_read(3, 0, '0, "R6 pointer 08-09-00");

    // flag behaviour
    wbuf[0] = 8'h00; do_write(4'd9, 1);
    do_write(4'd9, 0); do_read(1, 0, '0, "R9 flag cleared by 0");
    wbuf[0] = 8'hFF; do_write(4'd9, 1);
    do_write(4'd9, 0); do_read(1, 0, '0, "R9 flag not set by 1");
    osc_pulse();
    do_write(4'd9, 0); do_read(1, 0, '0, "R9 flag set by stop edge");
    wbuf[0] = 8'h80; do_write(4'd9, 1);
    do_write(4'd9, 0); do_read(1, 0, '0, "R9 flag kept by write of 1");

    // unused pointer value
    do_write(4'd12, 0);
    do_read(2, 0, '0, "R6 pointer above 09h");

    // repeated start aborts byte in progress
    wn0 = wn;
    bstart();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h07, ak);
    mptr = 4'd7;
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    bstart();
    send_byte({DEV, 1'b1}, ak);
    chk("R2 repeated start address ack", ak, 1);
    recv_byte(1'b0, b);
    chk("R2 read after repeated start", b, mctrl);
    mptr = fstep(mptr); msnap = live_time;
    bstop();
    wt(4);
    chk("R2 aborted byte not written", wn - wn0, 0);

    // power fail
    pwr_fail = 1;
    bstart();
    send_byte({DEV, 1'b0}, ak);
    chk("R10 address blocked", ak, 0);
    bstop();
    pwr_fail = 0;
    bstart();
    send_byte({DEV, 1'b0}, ak);
    send_byte(8'h07, ak);
    mptr = 4'd7;
    pwr_fail = 1;
    send_byte(8'hC3, ak);
    chk("R10 data byte not acked", ak, 0);
    bstop();
    pwr_fail = 0;
    wt(4);
    chk("R10 no write during power fail", wn - wn0, 0);
    chk("R10 ctrl unchanged", ctrl, mctrl);

    // random mix
    for (int it = 0; it < 14; it++) begin
      logic [3:0] p;
      int n;
      live_time = {$urandom, $urandom};
      p = 4'($urandom % 16);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(p, n);
      do_write(4'($urandom % 16), 0);
      do_read(3, 0, '0, "R5 random read");
    end
    chk_wlog("R3 random write strobes");
    chk("R4 ctrl after random", ctrl, mctrl);
    chk("R8 trickle after random", trickle, mtrk);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule